// File: doc/BRIEF.md
# Quarter-Duty LCD Drive Sequencer

This block produces the time-multiplexed drive for a liquid-crystal panel with four common lines and a parameterised number of segment lines (41 by default). Every frame is split into four equal slots, one per common line. For each pin and each slot the block outputs a two-bit level code. A separate analog stage turns this code into a rail or a bias voltage. The segment state comes from a flat display vector that holds four bits per segment, one bit for each common line.

Several run-time controls shape the drive. A bias input chooses between third-level and half-level drive. A blanking input forces every segment to its unlit waveform. A sleep input pulls all common and segment codes to ground. A two-bit port selector turns up to four of the lowest segment pins into static general-purpose outputs; these ports keep their levels during blanking and during sleep. Drive polarity is inverted on every other frame, so the panel sees no net DC voltage. All codes are registered and change together, only at slot boundaries.

Top module: `lcd_quad_drive`

## Requirements
- R1: Segment s and common c (both counted from 0) are lit by display bit disp_bits[4*s + c].
- R2: Output codes change only on the clock edge that ends a slot. A slot lasts SLOT_CYCLES clocks; the first slot after reset begins SLOT_CYCLES clocks after reset is released. Inputs are sampled on that same edge.
- R3: Level codes are 0 = ground, 1 = one-third (or one-half under half bias), 2 = two-thirds, 3 = full rail. In slot c, common c is the selected common and drives the rail (3 in a positive frame, 0 in a negative frame). The other commons drive 1 in a positive frame and 2 in a negative frame under third bias.
- R4: A lit segment drives the rail opposite the selected common. An unlit segment under third bias drives 2 in a positive frame and 1 in a negative frame.
- R5: Slots run in the order 0,1,2,3. Frames alternate positive and negative, and the first frame after reset is positive.
- R6: bias_half = 0 selects third bias. bias_half = 1 selects half bias: unselected commons drive 1, and unlit segments drive the same code as the selected common.
- R7: When blank = 1, every segment pin that is not a port drives the unlit code, whatever the display bits hold.
- R8: port_sel gives the number of port pins counted from segment 0: 0 gives none, 1 gives one, 2 gives three, 3 gives four.
- R9: Port pin k drives code 3 when disp_bits[4*k] is 1 and code 0 otherwise, in every slot and in both polarities.
- R10: When sleep = 1, every common pin and every non-port segment pin drives code 0; port pins keep their levels.
- R11: While rst_n is low, and until the first slot boundary after it is released, every output code is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_bits | input | 4*NUM_SEG | Display vector, four bits per segment |
| bias_half | input | 1 | 0 = third bias, 1 = half bias |
| blank | input | 1 | Force all non-port segments unlit |
| sleep | input | 1 | Force commons and non-port segments to ground |
| port_sel | input | 2 | Number of low segment pins used as static ports |
| com_lvl | output | 8 | Level codes for the four commons, common c at bits [2c+1:2c] |
| seg_lvl | output | 2*NUM_SEG | Level codes for the segments, segment s at bits [2s+1:2s] |

## Verification
Static port drive and multiplexed segment drive can both act on the lowest four pins in the same slot. Sleep or blanking can arrive in the same slot as a port-count change. The bench provokes these overlaps by enabling ports together with sleep, blanking and both bias modes, and by changing inputs part-way through a slot. A behavioural reference model expresses voltages in sixths of the supply. On every clock it is compared with each common and segment code, including the pins that pass between port and segment duty.

// File: rtl/lcd_quad_drive.sv
module lcd_quad_drive #(
  parameter int NUM_SEG     = 41,
  parameter int SLOT_CYCLES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [4*NUM_SEG-1:0]   disp_bits,
  input  logic                   bias_half,
  input  logic                   blank,
  input  logic                   sleep,
  input  logic [1:0]             port_sel,
  output logic [7:0]             com_lvl,
  output logic [2*NUM_SEG-1:0]   seg_lvl
);
  localparam int NUM_COM = 4;
  localparam int MAX_PORT = 4;
  localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [1:0] GND = 2'd0, LOW = 2'd1, HIGH = 2'd2, RAIL = 2'd3;

  logic [CW-1:0] cnt_q;
  logic [1:0]    slot_q;
  logic          neg_q;
  logic          run_q;
  logic          slp_q;

  logic          edge_w;
  logic [1:0]    slot_n;
  logic          neg_n;
  logic [1:0]    sel_l, unsel_l, on_l, off_l;
  logic [2:0]    nports;
  logic [7:0]             com_n;
  logic [2*NUM_SEG-1:0]   seg_n;

  assign edge_w  = (cnt_q == CW'(SLOT_CYCLES - 1));
  assign slot_n  = slot_q + 2'd1;
  assign neg_n   = (slot_q == 2'd3) ? ~neg_q : neg_q;

  assign sel_l   = neg_n ? GND : RAIL;
  assign on_l    = neg_n ? RAIL : GND;
  assign unsel_l = bias_half ? LOW : (neg_n ? HIGH : LOW);
  assign off_l   = bias_half ? sel_l : (neg_n ? LOW : HIGH);

  always_comb begin
    case (port_sel)
      2'd0:    nports = 3'd0;
      2'd1:    nports = 3'd1;
      2'd2:    nports = 3'd3;
      default: nports = 3'd4;
    endcase
  end

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    assign com_n[2*c +: 2] = sleep ? GND : ((slot_n == 2'(c)) ? sel_l : unsel_l);
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [3:0] grp;
    logic       lit;
    logic [1:0] mux_l;
    assign grp   = disp_bits[4*s +: 4];
    assign lit   = grp[slot_n] & ~blank;
    assign mux_l = sleep ? GND : (lit ? on_l : off_l);
    if (s < MAX_PORT) begin : g_port
      logic is_port;
      assign is_port = (nports > 3'(s));
      assign seg_n[2*s +: 2] = is_port ? {2{grp[0]}} : mux_l;
    end else begin : g_plain
      assign seg_n[2*s +: 2] = mux_l;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      slot_q  <= 2'd3;
      neg_q   <= 1'b1;
      run_q   <= 1'b0;
      slp_q   <= 1'b0;
      com_lvl <= '0;
      seg_lvl <= '0;
    end else if (edge_w) begin
      cnt_q   <= '0;
      slot_q  <= slot_n;
      neg_q   <= neg_n;
      run_q   <= 1'b1;
      slp_q   <= sleep;
      com_lvl <= com_n;
      seg_lvl <= seg_n;
    end else begin
      cnt_q   <= cnt_q + CW'(1);
    end
  end
endmodule

module lcd_quad_drive_chk #(
  parameter int NUM_SEG = 41,
  parameter int CW      = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [7:0]           com_lvl,
  input logic [2*NUM_SEG-1:0] seg_lvl,
  input logic [CW-1:0]        cnt_q,
  input logic                 run_q,
  input logic                 slp_q
);
  logic [3:0] rail;
  always_comb
    for (int c = 0; c < 4; c++)
      rail[c] = (com_lvl[2*c +: 2] == 2'd0) || (com_lvl[2*c +: 2] == 2'd3);

  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> ($stable(com_lvl) && $stable(seg_lvl)));

  // R3
  one_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !slp_q) |-> ($countones(rail) == 1));

  // R10
  sleep_ground_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slp_q |-> (com_lvl == 8'd0));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (com_lvl == 8'd0 && seg_lvl == '0));
endmodule

bind lcd_quad_drive lcd_quad_drive_chk #(.NUM_SEG(NUM_SEG), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
  .cnt_q(cnt_q), .run_q(run_q), .slp_q(slp_q)
);

// File: tb/test_lcd_quad_drive.sv
module test_lcd_quad_drive;
  localparam int NS = 41;
  localparam int SLOT = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic [4*NS-1:0] disp_bits = '0;
  logic bias_half = 0, blank = 0, sleep = 0;
  logic [1:0] port_sel = 0;
  logic [7:0] com_lvl;
  logic [2*NS-1:0] seg_lvl;

  lcd_quad_drive #(.NUM_SEG(NS), .SLOT_CYCLES(SLOT)) i_lcd_quad_drive (
    .clk(clk), .rst_n(rst_n), .disp_bits(disp_bits), .bias_half(bias_half),
    .blank(blank), .sleep(sleep), .port_sel(port_sel),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl));

  always #5 clk = ~clk;

  int compared = 0, mismatched = 0;
  string phase = "R11 reset";
  int edges = 0;
  logic [7:0] exp_com = '0;
  logic [2*NS-1:0] exp_seg = '0;

  function automatic logic [1:0] code_of(int sixths);
    case (sixths)
      0: return 2'd0;
      2, 3: return 2'd1;
      4: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  // Reference model: voltages in sixths of the supply.
  always @(posedge clk) begin
    if (!rst_n) begin
      edges = 0; exp_com = '0; exp_seg = '0;
    end else begin
      edges++;
      if (edges % SLOT == 0) begin
        int k, slot, nport, vsel, vuns, von, voff;
        bit neg;
        k = edges / SLOT;
        slot = (k - 1) % 4;
        neg = (((k - 1) / 4) % 2) == 1;
        vsel = neg ? 0 : 6;
        vuns = bias_half ? 3 : (neg ? 4 : 2);
        von  = 6 - vsel;
        voff = bias_half ? vsel : (neg ? 2 : 4);
        nport = (port_sel == 0) ? 0 : (port_sel == 1) ? 1 : (port_sel == 2) ? 3 : 4;
        for (int c = 0; c < 4; c++)
          exp_com[2*c +: 2] = sleep ? 2'd0 : code_of(c == slot ? vsel : vuns);
        for (int s = 0; s < NS; s++) begin
          if (s < nport)
            exp_seg[2*s +: 2] = disp_bits[4*s] ? 2'd3 : 2'd0;
          else if (sleep)
            exp_seg[2*s +: 2] = 2'd0;
          else
            exp_seg[2*s +: 2] = code_of((disp_bits[4*s + slot] && !blank) ? von : voff);
        end
      end
    end
  end

  always @(negedge clk) begin
    logic [7:0] ec;
    logic [2*NS-1:0] es;
    ec = rst_n ? exp_com : '0;
    es = rst_n ? exp_seg : '0;
    compared += 2;
    if (com_lvl !== ec) begin
      mismatched++;
      $display("FAIL %s commons: got %h expected %h", phase, com_lvl, ec);
    end
    if (seg_lvl !== es) begin
      mismatched++;
      $display("FAIL %s segments: got %h expected %h", phase, seg_lvl, es);
    end
  end

  task automatic wait_drive(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  function automatic logic [4*NS-1:0] pattern(int seed);
    logic [4*NS-1:0] v;
    for (int i = 0; i < 4*NS; i++) v[i] = ((i * 7 + seed) % 5) < 2;
    return v;
  endfunction

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    wait_drive(3);
    rst_n = 1;
    disp_bits = pattern(1);
    phase = "R11 idle after reset";
    wait_drive(SLOT - 1);
    phase = "R1 R4 R5 third bias";
    wait_drive(8 * SLOT + 3);
    phase = "R2 mid-slot change";
    disp_bits = pattern(3);
    wait_drive(3);
    disp_bits = {NS{4'b0101}};
    wait_drive(8 * SLOT + 5);
    phase = "R6 half bias";
    bias_half = 1;
    disp_bits = pattern(4);
    wait_drive(8 * SLOT);
    phase = "R7 blank";
    blank = 1;
    port_sel = 2;
    wait_drive(8 * SLOT + 1);
    blank = 0;
    bias_half = 0;
    for (int p = 1; p < 4; p++) begin
      phase = "R8 R9 port count";
      port_sel = 2'(p);
      disp_bits = pattern(p + 5);
      wait_drive(8 * SLOT + 2);
    end
    phase = "R10 sleep with ports";
    sleep = 1;
    wait_drive(8 * SLOT);
    bias_half = 1;
    port_sel = 1;
    wait_drive(4 * SLOT + 3);
    phase = "R10 wake";
    sleep = 0;
    wait_drive(4 * SLOT);
    phase = "R11 reset mid-slot";
    rst_n = 0;
    wait_drive(5);
    rst_n = 1;
    port_sel = 0;
    bias_half = 0;
    wait_drive(8 * SLOT);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule